// File: doc/BRIEF.md
# Serial Port with Two-Entry Receive Queue and Ninth Bit

This block is a full-duplex asynchronous serial port. It sends and receives frames made of one low start bit, eight data bits with the least significant bit first, an optional ninth bit, and one high stop bit. The ninth bit carries either a parity bit or a bit that software sets. When the ninth bit is off, the receiver keeps the level of the stop bit in its place. A baud tick at sixteen times the bit rate paces both directions.

Software controls the port through a small register port. Address 0 is a byte-wide control and status register. A write to address 1 queues a byte for transmission. A read of address 2 takes the oldest byte out of a two-entry receive queue. The register holds sticky flags for a finished transmission, a finished reception, a receive overrun and a parity error, plus a receive enable. The interrupt output is high while either completion flag is set. Configuration pins choose extra-bit mode, parity enable and the parity type.

Top module: `serial9_port`

## Requirements
- R1: Address 0 is the control register. It reads as 8'h20 after reset. Bit 5 always reads 1 and ignores writes. Bits 7, 6, 4, 3, 2, 1 and 0 take the value written to them.
- R2: Bit 7, the overrun flag, is set when a frame completes while the receive queue holds two bytes and no byte is being read. That frame is discarded. The flag stays set until software writes a 0 to it.
- R3: With parity enabled, bit 6 is set when a byte whose received ninth bit does not match its computed parity becomes the oldest entry in the queue. Writing 0 clears it, even if that byte is still the oldest entry.
- R4: Bit 4 is receive enable. While it is 0, no frame is accepted and bit 0 stays clear. Reads of address 2 still return data.
- R5: The ninth bit is present when cfg_xbit or cfg_par_en is 1. With parity enabled, it is the parity of the data byte and bit 3 is ignored. The parity type is set by cfg_par_sel: 0 gives odd parity, 1 even, 2 always 1 and 3 always 0. With parity off, the ninth bit is the value of bit 3.
- R6: At the end of each received frame, bit 2 captures the ninth bit when cfg_xbit is 1, and the stop-bit level when cfg_xbit is 0.
- R7: Bit 1 is set when a transmitted frame enters its stop bit, and not before.
- R8: Bit 0 is set when a received byte is stored. The irq output is high exactly while bit 0 or bit 1 is set.
- R9: The receive queue holds two bytes and returns them oldest first. A read of address 2 while the queue is empty returns the last byte read (0 after reset) and changes nothing.
- R10: The line idles high. Each bit lasts 16 ticks. A frame is a 0 start bit, 8 data bits with the least significant first, the optional ninth bit, and a 1 stop bit.
- R11: The receiver confirms a start bit at its midpoint, 8 ticks after the falling edge, and samples each later bit 16 ticks after the previous sample. A start bit that is high again at its midpoint returns the receiver to idle, and nothing is stored.
- R12: A byte written to address 1 while a frame is being sent is held. It is sent starting within one clock after the current stop bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Baud tick at 16 times the bit rate |
| cfg_xbit | input | 1 | Extra-bit mode |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_sel | input | 2 | Parity type: 0 odd, 1 even, 2 always 1, 3 always 0 |
| reg_addr | input | 2 | Register address: 0 control, 1 transmit data, 2 receive queue |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (takes a byte out of the queue at address 2) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| irq | output | 1 | Interrupt request |

## Verification
Most internal faults in this block show up at the ports within one frame time. A wrong bit index or tick count shifts or corrupts the byte that comes back through the loopback. A wrong stop-bit decode moves the transmit flag across a bit-midpoint boundary. A wrong queue count or pointer shows up when two or three back-to-back frames are read back, as a lost byte, a byte in the wrong order or a false overrun. A parity flag raised at the wrong time is caught by frames whose bad byte sits second in the queue: there the flag must stay clear until a read makes that byte the oldest.

// File: rtl/serial9_port.sv
module serial9_port #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_xbit,
  input  logic       cfg_par_en,
  input  logic [1:0] cfg_par_sel,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       irq
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] sel);
    case (sel)
      2'd0:    return ~^d;
      2'd1:    return ^d;
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  logic ovr, perr, ren, tbx, rbx, tflag, rflag;
  logic unused_wbit;
  assign unused_wbit = reg_wdata[5];

  wire wr_ctl = reg_wr && reg_addr == 2'd0;
  wire wr_tx  = reg_wr && reg_addr == 2'd1;
  wire rd_rx  = reg_rd && reg_addr == 2'd2;

  // transmitter
  logic          tx_busy, tx_bfull;
  logic [7:0]    tx_buf;
  logic [10:0]   tx_sh;
  logic [3:0]    tx_idx, tx_last;
  logic [CW-1:0] tx_cnt;

  wire tx_nine   = cfg_xbit | cfg_par_en;
  wire tx_ninth  = cfg_par_en ? par_bit(tx_buf, cfg_par_sel) : tbx;
  wire tx_step   = tx_busy && tick && tx_cnt == LAST;
  wire tflag_set = tx_step && tx_idx == tx_last - 4'd1;
  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy  <= 1'b0;
      tx_bfull <= 1'b0;
      tx_buf   <= '0;
      tx_sh    <= '1;
      tx_idx   <= '0;
      tx_last  <= '0;
      tx_cnt   <= '0;
    end else begin
      if (!tx_busy && tx_bfull) begin
        tx_busy  <= 1'b1;
        tx_bfull <= 1'b0;
        tx_sh    <= tx_nine ? {1'b1, tx_ninth, tx_buf, 1'b0} : {2'b11, tx_buf, 1'b0};
        tx_last  <= tx_nine ? 4'd10 : 4'd9;
        tx_idx   <= '0;
        tx_cnt   <= '0;
      end else if (tx_busy && tick) begin
        if (tx_cnt == LAST) begin
          tx_cnt <= '0;
          if (tx_idx == tx_last) begin
            tx_busy <= 1'b0;
          end else begin
            tx_idx <= tx_idx + 4'd1;
            tx_sh  <= {1'b1, tx_sh[10:1]};
          end
        end else begin
          tx_cnt <= tx_cnt + 1'b1;
        end
      end
      if (wr_tx) begin
        tx_buf   <= reg_wdata;
        tx_bfull <= 1'b1;
      end
    end
  end

  // receiver
  logic [1:0]    rx_sync;
  logic          rx_busy, rx_b9;
  logic [3:0]    rx_idx, rx_last;
  logic [CW-1:0] rx_cnt;
  logic [7:0]    rx_sh;

  wire rx_in   = rx_sync[1];
  wire rx_samp = rx_busy && tick && (rx_idx == 4'd0 ? rx_cnt == MID : rx_cnt == LAST);
  wire rx_done = rx_samp && rx_idx == rx_last;
  wire bad_in  = cfg_par_en && (rx_b9 != par_bit(rx_sh, cfg_par_sel));
  wire rbx_cap = cfg_xbit ? rx_b9 : rx_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync <= 2'b11;
      rx_busy <= 1'b0;
      rx_b9   <= 1'b0;
      rx_idx  <= '0;
      rx_last <= '0;
      rx_cnt  <= '0;
      rx_sh   <= '0;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      if (!rx_busy) begin
        if (ren && !rx_in) begin
          rx_busy <= 1'b1;
          rx_idx  <= '0;
          rx_cnt  <= '0;
          rx_last <= (cfg_xbit | cfg_par_en) ? 4'd10 : 4'd9;
        end
      end else if (rx_samp) begin
        rx_cnt <= '0;
        if (rx_idx == 4'd0) begin
          if (rx_in) rx_busy <= 1'b0;
          else       rx_idx  <= 4'd1;
        end else if (rx_idx == rx_last) begin
          rx_busy <= 1'b0;
        end else if (rx_idx <= 4'd8) begin
          rx_sh  <= {rx_in, rx_sh[7:1]};
          rx_idx <= rx_idx + 4'd1;
        end else begin
          rx_b9  <= rx_in;
          rx_idx <= rx_idx + 4'd1;
        end
      end else if (tick) begin
        rx_cnt <= rx_cnt + 1'b1;
      end
    end
  end

  // two-entry receive queue
  logic [1:0] f_cnt;
  logic [7:0] f_d0, f_d1, f_last;
  logic       f_b0, f_b1;

  wire       f_pop    = rd_rx && f_cnt != 2'd0;
  wire       f_push   = rx_done && (f_cnt != 2'd2 || f_pop);
  wire       ovr_set  = rx_done && !f_push;
  wire [1:0] f_slot   = f_cnt - {1'b0, f_pop};
  wire       perr_set = (f_push && f_slot == 2'd0 && bad_in) || (f_pop && f_cnt == 2'd2 && f_b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_cnt  <= '0;
      f_d0   <= '0;
      f_d1   <= '0;
      f_last <= '0;
      f_b0   <= 1'b0;
      f_b1   <= 1'b0;
    end else begin
      f_cnt <= f_cnt + {1'b0, f_push} - {1'b0, f_pop};
      if (f_pop) begin
        f_last <= f_d0;
        f_d0   <= f_d1;
        f_b0   <= f_b1;
      end
      if (f_push) begin
        if (f_slot == 2'd0) begin
          f_d0 <= rx_sh;
          f_b0 <= bad_in;
        end else begin
          f_d1 <= rx_sh;
          f_b1 <= bad_in;
        end
      end
    end
  end

  // control and status register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ovr, perr, ren, tbx, rbx, tflag, rflag} <= '0;
    end else begin
      if (wr_ctl) begin
        ovr   <= reg_wdata[7];
        perr  <= reg_wdata[6];
        ren   <= reg_wdata[4];
        tbx   <= reg_wdata[3];
        rbx   <= reg_wdata[2];
        tflag <= reg_wdata[1];
        rflag <= reg_wdata[0];
      end
      if (ovr_set)   ovr   <= 1'b1;
      if (perr_set)  perr  <= 1'b1;
      if (tflag_set) tflag <= 1'b1;
      if (f_push)    rflag <= 1'b1;
      if (rx_done)   rbx   <= rbx_cap;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {ovr, perr, 1'b1, ren, tbx, rbx, tflag, rflag};
      2'd2:    reg_rdata = (f_cnt != 2'd0) ? f_d0 : f_last;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = tflag | rflag;

  // R9
  fifo_depth_chk: assert property (@(posedge clk) disable iff (!rst_n) f_cnt != 2'd3);
  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && f_cnt == 2'd0 && !rx_done) |=> (f_cnt == 2'd0 && $stable(f_last)));
  // R2
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovr) && !$past(wr_ctl)) |-> $past(rx_done && f_cnt == 2'd2));
  // R3
  perr_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(perr) && !$past(wr_ctl)) |-> (f_cnt != 2'd0 && f_b0));
  // R7
  tflag_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tflag) && !$past(wr_ctl)) |-> (tx_busy && txd && tx_idx == tx_last));
  // R4
  ren_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren && !rx_busy) |=> !rx_busy);
  // R12
  tx_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_busy) && tx_bfull) |=> tx_busy);
endmodule

// File: tb/serial9_port_bench.sv
module serial9_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cfg_xbit = 1'b0, cfg_par_en = 1'b0;
  logic [1:0] cfg_par_sel = 2'd0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       txd, irq;
  logic       rx_drv = 1'b1, use_loop = 1'b1;
  wire        rxd = use_loop ? txd : rx_drv;

  int n_chk = 0, n_bad = 0;

  serial9_port u_serial9_port (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_xbit(cfg_xbit), .cfg_par_en(cfg_par_en), .cfg_par_sel(cfg_par_sel),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .txd(txd), .rxd(rxd), .irq(irq)
  );

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  // {data[7:0], xbit, par_en, par_sel[1:0], tbx, expected ninth, expected bit 2}
  localparam logic [14:0] VEC [0:7] = '{
    {8'hA5, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1},
    {8'h3C, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1},
    {8'h3C, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
    {8'h01, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1},
    {8'h01, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1},
    {8'hFF, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1},
    {8'h80, 1'b1, 1'b1, 2'd3, 1'b1, 1'b0, 1'b0},
    {8'h00, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic peek(output logic [7:0] d);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic send_rx(input logic [7:0] d, input logic nine, input logic b9);
    @(negedge clk);
    rx_drv = 1'b0; repeat (32) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx_drv = d[i]; repeat (32) @(negedge clk); end
    if (nine) begin rx_drv = b9; repeat (32) @(negedge clk); end
    rx_drv = 1'b1; repeat (64) @(negedge clk);
  endtask

  task automatic cap_tx(input logic nine, input int lim, output logic found,
                        output logic [7:0] d, output logic b9, output logic stp,
                        output logic t_pre, output logic t_post);
    found = 1'b0; d = '0; b9 = 1'b0; stp = 1'b0; t_pre = 1'b0; t_post = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (txd == 1'b0) begin found = 1'b1; break; end
    end
    if (found) begin
      repeat (16) @(negedge clk);
      for (int i = 0; i < 8; i++) begin repeat (32) @(negedge clk); d[i] = txd; end
      if (nine) begin repeat (32) @(negedge clk); b9 = txd; end
      t_pre = reg_rdata[1];
      repeat (32) @(negedge clk);
      stp = txd;
      t_post = reg_rdata[1];
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v, d;
    logic found, b9, stp, tpre, tpost, nine;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    peek(v);
    check("R1 reset value", v, 8'h20);
    check("R8 irq after reset", irq, 1'b0);
    check("R10 idle line", txd, 1'b1);
    rd_reg(2'd2, d);
    check("R9 empty read after reset", d, 8'h00);

    wr_reg(2'd0, 8'hDF); peek(v);
    check("R1 write all but bit 5", v, 8'hFF);
    check("R8 irq with flags set", irq, 1'b1);
    wr_reg(2'd0, 8'h00); peek(v);
    check("R1 bit 5 ignores write", v, 8'h20);

    for (int k = 0; k < 8; k++) begin
      cfg_xbit = VEC[k][6]; cfg_par_en = VEC[k][5]; cfg_par_sel = VEC[k][4:3];
      nine = VEC[k][6] | VEC[k][5];
      wr_reg(2'd0, {3'b000, 1'b1, VEC[k][2], 3'b000});
      wr_reg(2'd1, VEC[k][14:7]);
      cap_tx(nine, 200, found, d, b9, stp, tpre, tpost);
      check("R10 start bit seen", found, 1'b1);
      check("R10 transmitted data", d, VEC[k][14:7]);
      if (nine) check("R5 ninth bit", b9, VEC[k][1]);
      check("R10 stop bit", stp, 1'b1);
      check("R7 flag clear before stop", tpre, 1'b0);
      check("R7 flag set in stop", tpost, 1'b1);
      repeat (40) @(negedge clk);
      peek(v);
      check("R8 receive flag", v[0], 1'b1);
      check("R8 irq", irq, 1'b1);
      check("R3 no parity error", v[6], 1'b0);
      check("R6 captured bit", v[2], VEC[k][0]);
      rd_reg(2'd2, d);
      check("R11 received byte", d, VEC[k][14:7]);
    end

    cfg_xbit = 1'b0; cfg_par_en = 1'b0; cfg_par_sel = 2'd0;
    use_loop = 1'b0;
    wr_reg(2'd0, 8'h00);
    send_rx(8'h5A, 1'b0, 1'b0);
    peek(v);
    check("R4 no receive flag when disabled", v[0], 1'b0);
    rd_reg(2'd2, d);
    check("R4 queue untouched when disabled", d, 8'h00);

    wr_reg(2'd0, 8'h10);
    @(negedge clk); rx_drv = 1'b0;
    repeat (8) @(negedge clk); rx_drv = 1'b1;
    repeat (600) @(negedge clk);
    peek(v);
    check("R11 false start ignored", v[0], 1'b0);
    send_rx(8'h96, 1'b0, 1'b0);
    peek(v);
    check("R11 frame after false start", v[0], 1'b1);
    rd_reg(2'd2, d);
    check("R11 byte after false start", d, 8'h96);

    wr_reg(2'd0, 8'h10);
    send_rx(8'h11, 1'b0, 1'b0);
    send_rx(8'h22, 1'b0, 1'b0);
    send_rx(8'h33, 1'b0, 1'b0);
    peek(v);
    check("R2 overrun set", v[7], 1'b1);
    rd_reg(2'd2, d); check("R9 oldest first", d, 8'h11);
    rd_reg(2'd2, d); check("R9 second entry", d, 8'h22);
    rd_reg(2'd2, d); check("R9 empty read repeats last", d, 8'h22);
    peek(v);
    check("R2 overrun sticky", v[7], 1'b1);
    wr_reg(2'd0, 8'h10); peek(v);
    check("R2 overrun cleared by write", v[7], 1'b0);

    cfg_par_en = 1'b1; cfg_par_sel = 2'd1;
    send_rx(8'h01, 1'b1, 1'b0);
    peek(v);
    check("R3 parity error on head", v[6], 1'b1);
    wr_reg(2'd0, 8'h10);
    repeat (20) @(negedge clk);
    peek(v);
    check("R3 cleared while bad byte still head", v[6], 1'b0);
    rd_reg(2'd2, d);
    check("R3 bad byte readable", d, 8'h01);
    send_rx(8'h01, 1'b1, 1'b1);
    send_rx(8'h03, 1'b1, 1'b1);
    peek(v);
    check("R3 no error while good byte is head", v[6], 1'b0);
    rd_reg(2'd2, d);
    check("R3 good byte", d, 8'h01);
    peek(v);
    check("R3 error when bad byte becomes head", v[6], 1'b1);
    rd_reg(2'd2, d);
    check("R3 second byte", d, 8'h03);

    cfg_par_en = 1'b0; cfg_par_sel = 2'd0;
    use_loop = 1'b1;
    wr_reg(2'd0, 8'h10);
    wr_reg(2'd1, 8'h6B);
    wr_reg(2'd1, 8'hD4);
    cap_tx(1'b0, 200, found, d, b9, stp, tpre, tpost);
    check("R12 first byte", d, 8'h6B);
    cap_tx(1'b0, 40, found, d, b9, stp, tpre, tpost);
    check("R12 held byte starts right after stop", found, 1'b1);
    check("R12 held byte data", d, 8'hD4);
    repeat (40) @(negedge clk);
    rd_reg(2'd2, d); check("R12 loopback first", d, 8'h6B);
    rd_reg(2'd2, d); check("R12 loopback second", d, 8'hD4);

    wr_reg(2'd0, 8'h10);
    @(negedge clk);
    check("R8 irq clears with flags", irq, 1'b0);

    finish_run();
  end
endmodule